// File: doc/BRIEF.md
# Four-Phase Register-Machine Sequencer

This block is the control and datapath core of a small register-machine processor. Each instruction passes through four clock phases, and each phase has one fixed target. In the first phase the instruction register captures the word on the fetch port. In the second phase the two operand buffers capture their source registers. In the third phase the arithmetic path settles on the result bus. In the fourth phase the destination register or the memory data register is updated.

Two operations are decoded: a register-to-register add and a register-indirect store. Every other opcode is a no-operation. A store sends its base register through the arithmetic path into the memory address register. It then loads the memory data register and raises a bus request. The sequencer stays in the fourth phase until the external bus interface acknowledges the transfer.

The register file has sixteen 32-bit entries. Reset loads each entry with its own index, which gives software a known starting set of values that adds can combine.

Top module: `qp_core`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the phase to load (code 0), clears `bus_req`, `bus_addr` and `bus_wdata`, and loads every register k with the value k.
- R2: `phase` steps 0→1→2→3 on successive edges. Leaving phase 3 returns it to 0, except during a store stall.
- R3: `fetch_strobe` is high only in phase 0. The instruction register samples `fetch_word` only on the edge that ends phase 0, and the value of `fetch_word` in phases 1 to 3 has no effect.
- R4: Opcode bits [31:28] = 4'h0 is an add. On the edge that ends phase 3, register [23:20] is written with register [19:16] + register [15:12], modulo 2^32, using the values from before the write.
- R5: Opcode 4'h9 is a store with data register [23:20] and base register [19:16]. From the edge that ends phase 2, `bus_addr` holds the base value. From the edge that ends the first phase-3 cycle, `bus_wdata` holds the data value and `bus_req` is high.
- R6: While `bus_req` is high and `bus_ack` is low, `phase` stays at 3 and `bus_req` stays high. An edge with `bus_ack` high clears `bus_req` and moves `phase` to 0.
- R7: `bus_ack` has no effect while `bus_req` is low.
- R8: Any opcode other than 4'h0 and 4'h9 writes no register, raises no request and leaves `bus_addr` and `bus_wdata` unchanged.
- R9: Bits [27:24] and [11:0] are ignored by every instruction, and bits [15:12] are ignored by a store.
- R10: An add never changes `bus_addr` or `bus_wdata`, and a store never writes the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high |
| fetch_word | input | 32 | Instruction word from the fetch side |
| fetch_strobe | output | 1 | High in the phase where `fetch_word` is sampled |
| phase | output | 2 | Current phase, 0 to 3 |
| bus_req | output | 1 | Store transfer request |
| bus_ack | input | 1 | Store transfer acknowledge |
| bus_addr | output | 32 | Memory address register |
| bus_wdata | output | 32 | Memory data register |

## Verification
The register file has no read port at the block's edge, so the result of an add can only be seen through a later store. The stimulus uses stores as the read path: a store places the data register on `bus_wdata` and the base register on `bus_addr`. After every burst of adds, a sweep of sixteen stores reads every register out against an arithmetic model. A stall has to be held open for a chosen number of cycles before the acknowledge. The stimulus gets this by varying the acknowledge delay from zero to three cycles. During adds it also holds `bus_ack` high and drives corrupted words on `fetch_word` outside phase 0, to show that neither input has any effect.

// File: rtl/qp_pkg.sv
package qp_pkg;
    localparam int DATA_W   = 32;
    localparam int INSN_W   = 32;
    localparam int REG_CNT  = 16;
    localparam int SEL_W    = $clog2(REG_CNT);
    localparam int OPC_W    = 4;
    localparam int OPC_LSB  = 28;
    localparam int DST_LSB  = 20;
    localparam int SRCA_LSB = 16;
    localparam int SRCB_LSB = 12;
    localparam int GAP_LSB  = DST_LSB + SEL_W;
    localparam int GAP_W    = OPC_LSB - GAP_LSB;

    localparam logic [OPC_W-1:0] OPC_ADD   = 4'h0;
    localparam logic [OPC_W-1:0] OPC_STORE = 4'h9;

    typedef enum logic [1:0] {
        PH_LOAD   = 2'd0,
        PH_OPER   = 2'd1,
        PH_EVAL   = 2'd2,
        PH_COMMIT = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        K_NOP   = 2'd0,
        K_ADD   = 2'd1,
        K_STORE = 2'd2
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic [SEL_W-1:0] rd_sel_a;
        logic [SEL_W-1:0] rd_sel_b;
        logic [SEL_W-1:0] wr_sel;
    } ctrl_t;
endpackage

// File: rtl/qp_regfile.sv
module qp_regfile #(
    parameter int DW = 32,
    parameter int RC = 16,
    localparam int SW = $clog2(RC)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] ra_sel,
    input  logic [SW-1:0] rb_sel,
    output logic [DW-1:0] ra_data,
    output logic [DW-1:0] rb_data,
    input  logic          we,
    input  logic [SW-1:0] wsel,
    input  logic [DW-1:0] wdata
);
    logic [DW-1:0] mem_q [RC];
    logic [DW-1:0] mem_d [RC];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[wsel] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RC; i++) mem_q[i] <= DW'(i);
        end else begin
            mem_q <= mem_d;
        end
    end

    assign ra_data = mem_q[ra_sel];
    assign rb_data = mem_q[rb_sel];

    // R4
    write_land_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem_q[$past(wsel)] == $past(wdata)));
endmodule

// File: rtl/qp_decode.sv
module qp_decode
    import qp_pkg::*;
(
    input  logic [INSN_W-1:0] ir,
    output ctrl_t             ctrl
);
    logic [OPC_W-1:0] opc;
    logic [SEL_W-1:0] f_dst, f_a, f_b;
    logic             ir_unused;

    assign opc   = ir[OPC_LSB +: OPC_W];
    assign f_dst = ir[DST_LSB +: SEL_W];
    assign f_a   = ir[SRCA_LSB +: SEL_W];
    assign f_b   = ir[SRCB_LSB +: SEL_W];
    assign ir_unused = ^{ir[GAP_LSB +: GAP_W], ir[0 +: SRCB_LSB]};

    always_comb begin
        ctrl.kind     = K_NOP;
        ctrl.rd_sel_a = f_a;
        ctrl.rd_sel_b = f_b;
        ctrl.wr_sel   = f_dst;
        if (opc == OPC_ADD) begin
            ctrl.kind = K_ADD;
        end else if (opc == OPC_STORE) begin
            ctrl.kind     = K_STORE;
            ctrl.rd_sel_a = f_dst;
            ctrl.rd_sel_b = f_a;
        end
    end
endmodule

// File: rtl/qp_alu.sv
module qp_alu
    import qp_pkg::*;
#(
    parameter int DW = 32
) (
    input  kind_e         kind,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [DW-1:0] cbus
);
    always_comb begin
        unique case (kind)
            K_ADD:   cbus = opa + opb;
            K_STORE: cbus = opb;
            default: cbus = '0;
        endcase
    end
endmodule

// File: rtl/qp_core.sv
module qp_core
    import qp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int RC = REG_CNT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [INSN_W-1:0] fetch_word,
    output logic              fetch_strobe,
    output logic [1:0]        phase,
    output logic              bus_req,
    input  logic              bus_ack,
    output logic [DW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_wdata
);
    typedef struct packed {
        phase_e            phase;
        logic [INSN_W-1:0] ir;
        logic [DW-1:0]     a;
        logic [DW-1:0]     b;
        logic [DW-1:0]     mar;
        logic [DW-1:0]     mdr;
        logic              req;
    } core_st_t;

    core_st_t      s_d, s_q;
    ctrl_t         ctrl;
    logic [DW-1:0] rd_a, rd_b, cbus;
    logic          rf_we;
    logic [1:0]    ph_bits;

    qp_decode u_dec (.ir(s_q.ir), .ctrl(ctrl));

    qp_regfile #(.DW(DW), .RC(RC)) u_rf (
        .clk(clk), .rst(rst),
        .ra_sel(ctrl.rd_sel_a), .rb_sel(ctrl.rd_sel_b),
        .ra_data(rd_a), .rb_data(rd_b),
        .we(rf_we), .wsel(ctrl.wr_sel), .wdata(cbus)
    );

    qp_alu #(.DW(DW)) u_alu (.kind(ctrl.kind), .opa(s_q.a), .opb(s_q.b), .cbus(cbus));

    always_comb begin
        s_d   = s_q;
        rf_we = 1'b0;
        unique case (s_q.phase)
            PH_LOAD: begin
                s_d.ir    = fetch_word;
                s_d.phase = PH_OPER;
            end
            PH_OPER: begin
                s_d.a     = rd_a;
                s_d.b     = rd_b;
                s_d.phase = PH_EVAL;
            end
            PH_EVAL: begin
                if (ctrl.kind == K_STORE) s_d.mar = cbus;
                s_d.phase = PH_COMMIT;
            end
            PH_COMMIT: begin
                if (s_q.req) begin
                    if (bus_ack) begin
                        s_d.req   = 1'b0;
                        s_d.phase = PH_LOAD;
                    end
                end else begin
                    unique case (ctrl.kind)
                        K_ADD: begin
                            rf_we     = 1'b1;
                            s_d.phase = PH_LOAD;
                        end
                        K_STORE: begin
                            s_d.mdr = s_q.a;
                            s_d.req = 1'b1;
                        end
                        default: s_d.phase = PH_LOAD;
                    endcase
                end
            end
            default: s_d.phase = PH_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign ph_bits      = s_q.phase;
    assign phase        = ph_bits;
    assign fetch_strobe = (s_q.phase == PH_LOAD);
    assign bus_req      = s_q.req;
    assign bus_addr     = s_q.mar;
    assign bus_wdata    = s_q.mdr;

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_bits != 2'd3) |=> (ph_bits == $past(ph_bits) + 2'd1));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q.req && !bus_ack) |=> (s_q.req && ph_bits == 2'd3));

    // R6
    stall_release_chk: assert property (@(posedge clk) disable iff (rst)
        (s_q.req && bus_ack) |=> (!s_q.req && ph_bits == 2'd0));

    // R5
    req_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(s_q.req) |-> ($past(ph_bits) == 2'd3 && ph_bits == 2'd3));

    // R10
    mar_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_bits != 2'd2) |=> $stable(s_q.mar));

    // R10
    mdr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(ph_bits == 2'd3 && !s_q.req) |=> $stable(s_q.mdr));

    // R8
    nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_bits == 2'd3 && ctrl.kind == K_NOP) |=> (!s_q.req && ph_bits == 2'd0));
endmodule

// File: tb/qp_core_test.sv
`timescale 1ns/1ps
module qp_core_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] fetch_word;
    logic        fetch_strobe;
    logic [1:0]  phase;
    logic        bus_req;
    logic        bus_ack;
    logic [31:0] bus_addr;
    logic [31:0] bus_wdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] mregs [16];
    logic [31:0] last_addr, last_data;

    always #2 clk = ~clk;

    qp_core uut (
        .clk(clk), .rst(rst), .fetch_word(fetch_word), .fetch_strobe(fetch_strobe),
        .phase(phase), .bus_req(bus_req), .bus_ack(bus_ack),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] op, input logic [3:0] d,
                                        input logic [3:0] a, input logic [3:0] b,
                                        input logic [31:0] junk);
        return {op, junk[27:24], d, a, b, junk[11:0]};
    endfunction

    // Runs one instruction; entered just after a falling edge in phase 0.
    task automatic exec(input logic [31:0] w, input int lag, input bit ack_noise);
        logic [3:0] op, d, a, b;
        op = w[31:28]; d = w[23:20]; a = w[19:16]; b = w[15:12];
        chk("R2 phase0", 32'(phase), 32'd0);
        chk("R3 strobe", 32'(fetch_strobe), 32'd1);
        fetch_word = w;
        bus_ack    = (op != 4'h9) ? ack_noise : 1'b0;
        @(negedge clk);
        fetch_word = ~w;
        chk("R2 phase1", 32'(phase), 32'd1);
        chk("R3 strobe low", 32'(fetch_strobe), 32'd0);
        @(negedge clk);
        fetch_word = w ^ 32'h5A5A_C3C3;
        chk("R2 phase2", 32'(phase), 32'd2);
        @(negedge clk);
        fetch_word = 32'hFFFF_FFFF;
        chk("R2 phase3", 32'(phase), 32'd3);
        if (op == 4'h9) begin
            last_addr = mregs[a];
            chk("R5 addr", bus_addr, last_addr);
        end else begin
            chk("R10 R8 addr held", bus_addr, last_addr);
        end
        @(negedge clk);
        if (op == 4'h9) begin
            last_data = mregs[d];
            chk("R6 stall phase", 32'(phase), 32'd3);
            chk("R5 req", 32'(bus_req), 32'd1);
            chk("R5 wdata", bus_wdata, last_data);
            for (int k = 0; k < lag; k++) begin
                @(negedge clk);
                chk("R6 hold phase", 32'(phase), 32'd3);
                chk("R6 hold req", 32'(bus_req), 32'd1);
            end
            bus_ack = 1'b1;
            @(negedge clk);
            bus_ack = 1'b0;
            chk("R6 release phase", 32'(phase), 32'd0);
            chk("R6 release req", 32'(bus_req), 32'd0);
        end else begin
            if (op == 4'h0) mregs[d] = mregs[a] + mregs[b];
            bus_ack = 1'b0;
            chk("R2 wrap", 32'(phase), 32'd0);
            chk("R7 R8 no req", 32'(bus_req), 32'd0);
            chk("R10 R8 wdata held", bus_wdata, last_data);
            chk("R10 R8 addr held", bus_addr, last_addr);
        end
    endtask

    // Store sweep: reads every register out through the bus (R4, R9 on unused store bits).
    task automatic dump(input int salt);
        for (int k = 0; k < 16; k++) begin
            logic [31:0] junk;
            junk = 32'(k + salt) * 32'h9E37_79B9;
            exec(mk(4'h9, 4'(k), 4'((k + 1 + salt) % 16), junk[15:12], junk), (k + salt) % 4, 1'b0);
        end
    endtask

    initial begin
        rst = 1'b1; fetch_word = 32'h0; bus_ack = 1'b0;
        last_addr = 32'h0; last_data = 32'h0;
        for (int i = 0; i < 16; i++) mregs[i] = 32'(i);
        repeat (3) @(negedge clk);
        // R1
        chk("R1 phase", 32'(phase), 32'd0);
        chk("R1 req", 32'(bus_req), 32'd0);
        chk("R1 addr", bus_addr, 32'd0);
        chk("R1 wdata", bus_wdata, 32'd0);
        rst = 1'b0;
        dump(0);
        for (int i = 0; i < 240; i++) begin
            logic [31:0] junk;
            junk = 32'(i) * 32'h85EB_CA6B + 32'h1234_5678;
            exec(mk(4'h0, 4'((i * 3 + 1) % 16), 4'((i * 7) % 16), 4'((i * 5 + 3) % 16), junk),
                 0, (i % 3) == 0);
            if (i % 60 == 59) dump(i);
        end
        for (int op = 1; op < 16; op++) begin
            if (op != 9) exec(mk(4'(op), 4'(op), 4'(15 - op), 4'(op), 32'hFFFF_FFFF), 0, 1'b1);
        end
        dump(5);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule